// File: doc/BRIEF.md
# Multi-Channel Burst SPI Master

This block is an SPI master driven through a small word-addressed register port. Software fills a transmit word queue, sets a burst length in bits, chooses one of four select lines and writes the start bit. The engine then shifts the whole burst out on MOSI, most significant bit first. At the same time it collects MISO into a receive word queue. When the burst ends it sets a completion flag that software clears by writing a one to it.

Each select line has its own clock phase, clock polarity, select polarity and idle clock level, all held in one shared configuration word. The serial clock comes from the system clock. A 4-bit linear prescaler sets the half period, and a power-of-two postscaler multiplies it. A burst may be longer than one queue word. When its length is not a whole number of words, the short word is the first one.

Top module: `spi_burst_master`

## Requirements
- R1: After reset, all four select lines sit at their inactive level, which is high because the configuration word is zero. `sclk_o` and `mosi_o` are low, and the control, configuration and status words read zero.
- R2: Word index 1 pushes the TX queue. Index 0 pops the RX queue. Index 2 is control and reads back as written masked with 0xFFFCFFF5. Index 3 is configuration and reads back masked with 0x00F0F0FF. Index 6 is status. Indexes 4, 5 and 7 read zero and ignore writes.
- R3: A burst moves L = control[31:20] + 1 bits (1 to 4096), MSB first. The first TX word supplies its L mod 32 low-order bits, or all 32 bits when L is a multiple of 32. Every later word supplies all 32 bits.
- R4: Received bits form RX words with the same alignment: the first word is right-aligned with its upper bits zero, and later words are full. Words are pushed in order. A read of an empty RX queue returns zero.
- R5: For select line n, configuration bit n is the phase and bit 4+n is the polarity. The leading edge is the edge on which SCLK leaves its polarity level. With phase 0, MISO is sampled on the leading edge and MOSI changes on the trailing edge. With phase 1, MOSI changes on the leading edge and MISO is sampled on the trailing edge.
- R6: Control[19:18] picks the line, and configuration bit 12+n is line n's active level. The picked line is active from the start of the burst until half an SCLK period after the last edge. All other lines stay at their inactive level throughout, and all lines are inactive between bursts.
- R7: The SCLK half period is (pre+1)·2^post system clocks, where pre = control[15:12] and post = control[11:8].
- R8: Status bit 7 rises when a burst ends, and afterwards control bit 2 reads zero. Writing 1 to status bit 7 clears it.
- R9: When a received word completes while the 8-word RX queue is full, the word is dropped and status bit 6 is set. Writing 1 to status bit 6 clears it.
- R10: Writes to the control or configuration word during a burst are ignored, including a second start.
- R11: When the TX queue is empty at a point where a word is needed, the burst shifts zeros for that word.
- R12: A burst starts only when a control write has both bit 0 (enable) and bit 2 (start) set. With bit 0 clear, bit 2 is stored as zero and nothing moves.
- R13: Outside a burst, `sclk_o` follows configuration bit 20+n of the line picked in control.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | Write qualifier |
| bus_rd | input | 1 | Read qualifier (pops RX at index 0) |
| bus_addr | input | 3 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| ss_o | output | 4 | Select lines, level set per line |

## Verification
The assertions check on every cycle that:
- control and configuration hold still while a burst runs;
- at most one select line is ever away from its inactive level;
- a start always leads to a busy engine, and the end of a burst always drops busy and raises the completion flag;
- neither queue is pushed when full or popped when empty.

Only the bench scenarios can show the serial content itself: bit order, alignment of the short first word, the sampling edge for each phase and polarity, zero fill on an empty TX queue, and dropping of a word on RX overflow. The same holds for the measured SCLK period against the divider settings and for the exact count of edges per burst.

// File: rtl/sbm_pkg.sv
package sbm_pkg;
  localparam int DATA_W = 32;
  localparam int NCH    = 4;
  localparam int LEN_W  = 12;
  localparam int PRE_W  = 4;
  localparam int POST_W = 4;

  typedef enum logic [2:0] {
    REG_RXD  = 3'd0,
    REG_TXD  = 3'd1,
    REG_CTRL = 3'd2,
    REG_CFG  = 3'd3,
    REG_IEN  = 3'd4,
    REG_DMA  = 3'd5,
    REG_STAT = 3'd6,
    REG_PER  = 3'd7
  } reg_idx_e;

  localparam logic [DATA_W-1:0] CTRL_MASK = 32'hFFFC_FFF5;
  localparam logic [DATA_W-1:0] CFG_MASK  = 32'h00F0_F0FF;

  localparam int C_EN    = 0;
  localparam int C_START = 2;
  localparam int C_POST  = 8;
  localparam int C_PRE   = 12;
  localparam int C_CHAN  = 18;
  localparam int C_LEN   = 20;

  localparam int F_PHA   = 0;
  localparam int F_POL   = 4;
  localparam int F_SEL   = 12;
  localparam int F_IDLE  = 20;

  localparam int S_DONE  = 7;
  localparam int S_OVF   = 6;
endpackage

// File: rtl/sbm_fifo.sv
module sbm_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         full,
  output logic         empty
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q, wptr_d, rptr_d;
  logic [AW:0]   cnt_q, cnt_d;

  assign full  = (cnt_q == (AW+1)'(DEPTH));
  assign empty = (cnt_q == '0);
  assign rdata = mem[rptr_q];

  always_comb begin
    wptr_d = push ? ((wptr_q == AW'(DEPTH-1)) ? '0 : wptr_q + AW'(1)) : wptr_q;
    rptr_d = pop  ? ((rptr_q == AW'(DEPTH-1)) ? '0 : rptr_q + AW'(1)) : rptr_q;
    cnt_d  = cnt_q + (push ? (AW+1)'(1) : '0) - (pop ? (AW+1)'(1) : '0);
  end

  always_ff @(posedge clk) begin
    if (push) mem[wptr_q] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
    end
  end

  // R9: callers drop words rather than push into a full queue
  p_push_not_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  // R4: pops only ever take real entries
  p_pop_not_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/sbm_engine.sv
module sbm_engine
  import sbm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              cpha,
  input  logic              cpol,
  input  logic [LEN_W-1:0]  len_m1,
  input  logic [PRE_W-1:0]  pre,
  input  logic [POST_W-1:0] post,
  input  logic              tx_valid,
  input  logic [DATA_W-1:0] tx_word,
  output logic              tx_pop,
  output logic              rx_push,
  output logic [DATA_W-1:0] rx_word,
  input  logic              miso,
  output logic              sclk,
  output logic              mosi,
  output logic              busy,
  output logic              done
);
  localparam int CW = PRE_W + (1 << POST_W);
  localparam int BW = LEN_W + 1;
  localparam int WW = $clog2(DATA_W) + 1;

  logic              busy_q, busy_d, tail_q, tail_d, half_q, half_d;
  logic              sclk_q, sclk_d, mosi_q, mosi_d;
  logic [CW-1:0]     cnt_q, cnt_d, half_len;
  logic [BW-1:0]     bits_q, bits_d, len_p1;
  logic [WW-1:0]     wbits_q, wbits_d, fw_bits;
  logic [DATA_W-1:0] tx_sh_q, tx_sh_d, rx_sh_q, rx_sh_d, rx_next, load_word;
  logic              tick;

  assign half_len  = (CW'(pre) + CW'(1)) << post;
  assign tick      = busy_q && (cnt_q == half_len - CW'(1));
  assign len_p1    = BW'(len_m1) + BW'(1);
  assign fw_bits   = (len_p1[WW-2:0] == '0) ? WW'(DATA_W) : {1'b0, len_p1[WW-2:0]};
  assign load_word = tx_valid ? tx_word : '0;
  assign rx_next   = {rx_sh_q[DATA_W-2:0], miso};

  assign busy = busy_q;
  assign sclk = sclk_q;
  assign mosi = busy_q ? (cpha ? mosi_q : tx_sh_q[DATA_W-1]) : 1'b0;

  always_comb begin
    busy_d  = busy_q;  tail_d = tail_q;  half_d = half_q;
    sclk_d  = sclk_q;  mosi_d = mosi_q;  cnt_d  = cnt_q;
    bits_d  = bits_q;  wbits_d = wbits_q;
    tx_sh_d = tx_sh_q; rx_sh_d = rx_sh_q;
    tx_pop  = 1'b0;    rx_push = 1'b0;   done   = 1'b0;
    rx_word = rx_sh_q;
    if (!busy_q) begin
      if (start) begin
        busy_d  = 1'b1;  tail_d = 1'b0;  half_d = 1'b0;
        cnt_d   = '0;    sclk_d = cpol;  mosi_d = 1'b0;
        bits_d  = len_p1;
        wbits_d = fw_bits;
        tx_sh_d = load_word << (WW'(DATA_W) - fw_bits);
        rx_sh_d = '0;
        tx_pop  = tx_valid;
      end
    end else if (!tick) begin
      cnt_d = cnt_q + CW'(1);
    end else begin
      cnt_d = '0;
      if (tail_q) begin
        busy_d = 1'b0;
        tail_d = 1'b0;
        done   = 1'b1;
      end else if (!half_q) begin
        half_d = 1'b1;
        sclk_d = ~cpol;
        if (cpha) mosi_d  = tx_sh_q[DATA_W-1];
        else      rx_sh_d = rx_next;
      end else begin
        half_d = 1'b0;
        sclk_d = cpol;
        if (cpha) rx_sh_d = rx_next;
        bits_d = bits_q - BW'(1);
        if (wbits_q == WW'(1)) begin
          rx_push = 1'b1;
          rx_word = cpha ? rx_next : rx_sh_q;
          wbits_d = WW'(DATA_W);
          tx_sh_d = load_word;
          tx_pop  = tx_valid && (bits_q != BW'(1));
        end else begin
          wbits_d = wbits_q - WW'(1);
          tx_sh_d = tx_sh_q << 1;
        end
        if (bits_q == BW'(1)) tail_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; tail_q <= 1'b0; half_q <= 1'b0;
      sclk_q <= 1'b0; mosi_q <= 1'b0; cnt_q  <= '0;
      bits_q <= '0;   wbits_q <= '0;
      tx_sh_q <= '0;  rx_sh_q <= '0;
    end else begin
      busy_q <= busy_d; tail_q <= tail_d; half_q <= half_d;
      sclk_q <= sclk_d; mosi_q <= mosi_d; cnt_q  <= cnt_d;
      bits_q <= bits_d; wbits_q <= wbits_d;
      tx_sh_q <= tx_sh_d; rx_sh_q <= rx_sh_d;
    end
  end

  p_start_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy_q |=> busy_q);
  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy_q);
  p_pop_has_word_r11: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop |-> tx_valid);
endmodule

// File: rtl/spi_burst_master.sv
module spi_burst_master
  import sbm_pkg::*;
#(
  parameter int FIFO_DEPTH  = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [2:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              sclk_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic [NCH-1:0]    ss_o
);
  localparam int CHW = $clog2(NCH);

  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_s = rst_sync_q[SYNC_STAGES-1];

  logic [DATA_W-1:0] ctrl_q, ctrl_d, cfg_q, cfg_d;
  logic              ctrl_en, cfg_en, start_q, start_d;
  logic              tc_q, tc_d, ovf_q, ovf_d;
  logic              wr_hit, rd_hit, lock;
  logic              busy, done, tx_pop, rx_push;
  logic              tx_full, tx_empty, rx_full, rx_empty;
  logic [DATA_W-1:0] tx_word, rx_word, rx_data;
  logic [CHW-1:0]    chan;

  assign wr_hit = bus_sel && bus_wr;
  assign rd_hit = bus_sel && bus_rd;
  assign lock   = busy || start_q;
  assign chan   = ctrl_q[C_CHAN +: CHW];

  always_comb begin
    ctrl_en = (wr_hit && bus_addr == REG_CTRL && !lock) || done;
    ctrl_d  = ctrl_q;
    start_d = 1'b0;
    if (done) begin
      ctrl_d[C_START] = 1'b0;
    end else if (ctrl_en) begin
      ctrl_d          = bus_wdata & CTRL_MASK;
      ctrl_d[C_START] = bus_wdata[C_START] && bus_wdata[C_EN];
      start_d         = ctrl_d[C_START];
    end
    cfg_en = wr_hit && bus_addr == REG_CFG && !lock;
    cfg_d  = bus_wdata & CFG_MASK;
    tc_d   = done || (tc_q && !(wr_hit && bus_addr == REG_STAT && bus_wdata[S_DONE]));
    ovf_d  = (rx_push && rx_full) ||
             (ovf_q && !(wr_hit && bus_addr == REG_STAT && bus_wdata[S_OVF]));
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      ctrl_q  <= '0;
      cfg_q   <= '0;
      start_q <= 1'b0;
      tc_q    <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      if (ctrl_en) ctrl_q <= ctrl_d;
      if (cfg_en)  cfg_q  <= cfg_d;
      start_q <= start_d;
      tc_q    <= tc_d;
      ovf_q   <= ovf_d;
    end
  end

  always_comb begin
    case (bus_addr)
      REG_RXD:  bus_rdata = rx_empty ? '0 : rx_data;
      REG_CTRL: bus_rdata = ctrl_q;
      REG_CFG:  bus_rdata = cfg_q;
      REG_STAT: bus_rdata = DATA_W'({tc_q, ovf_q}) << S_OVF;
      default:  bus_rdata = '0;
    endcase
  end

  sbm_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_s),
    .push(wr_hit && bus_addr == REG_TXD && !tx_full), .wdata(bus_wdata),
    .pop(tx_pop), .rdata(tx_word), .full(tx_full), .empty(tx_empty));

  sbm_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_s),
    .push(rx_push && !rx_full), .wdata(rx_word),
    .pop(rd_hit && bus_addr == REG_RXD && !rx_empty), .rdata(rx_data),
    .full(rx_full), .empty(rx_empty));

  logic eng_sclk;

  sbm_engine u_eng (
    .clk(clk), .rst_n(rst_s), .start(start_q),
    .cpha(cfg_q[F_PHA + chan]), .cpol(cfg_q[F_POL + chan]),
    .len_m1(ctrl_q[C_LEN +: LEN_W]), .pre(ctrl_q[C_PRE +: PRE_W]),
    .post(ctrl_q[C_POST +: POST_W]),
    .tx_valid(!tx_empty), .tx_word(tx_word), .tx_pop(tx_pop),
    .rx_push(rx_push), .rx_word(rx_word), .miso(miso_i),
    .sclk(eng_sclk), .mosi(mosi_o), .busy(busy), .done(done));

  assign sclk_o = busy ? eng_sclk : cfg_q[F_IDLE + chan];

  for (genvar n = 0; n < NCH; n++) begin : g_sel
    assign ss_o[n] = (busy && chan == CHW'(n)) ? cfg_q[F_SEL + n] : ~cfg_q[F_SEL + n];
  end

  p_regs_frozen_r10: assert property (@(posedge clk) disable iff (!rst_s)
    busy && $past(busy) |-> $stable(ctrl_q) && $stable(cfg_q));
  p_one_select_r6: assert property (@(posedge clk) disable iff (!rst_s)
    $onehot0(ss_o ^ ~cfg_q[F_SEL +: NCH]));
  p_flag_on_done_r8: assert property (@(posedge clk) disable iff (!rst_s)
    done |=> tc_q);
endmodule

// File: tb/sim_spi_burst_master.sv
module sim_spi_burst_master;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_wr, bus_rd;
  logic [2:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        sclk_o, mosi_o, miso_i;
  logic [3:0]  ss_o;
  logic        inv_b;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign miso_i = mosi_o ^ inv_b;

  spi_burst_master u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sclk_o(sclk_o), .mosi_o(mosi_o), .miso_i(miso_i), .ss_o(ss_o));

  // serial monitor
  logic       mon_on = 1'b0;
  int         mon_ch = 0;
  logic       mon_pol = 1'b0, mon_pha = 1'b0, mon_ssp = 1'b0;
  logic [3:0] mon_act_pat = 4'hF;
  int         mon_per = 2;
  logic       cap [0:4095];
  int         cap_n = 0, per_cnt = 0, per_bad = 0, ss_bad = 0;
  logic       have_lead = 1'b0, prev_sclk = 1'b0, prev_act = 1'b0;

  always @(negedge clk) begin
    logic act, lead;
    act = mon_on && (ss_o[mon_ch] == mon_ssp);
    per_cnt++;
    if (prev_act && act && sclk_o != prev_sclk) begin
      lead = (sclk_o != mon_pol);
      if (lead) begin
        if (have_lead && per_cnt != mon_per) per_bad++;
        have_lead = 1'b1;
        per_cnt   = 0;
        if (ss_o != mon_act_pat) ss_bad++;
      end
      if (lead != mon_pha) begin
        if (cap_n < 4096) cap[cap_n] = mosi_o;
        cap_n++;
      end
    end
    prev_sclk = sclk_o;
    prev_act  = act;
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0; bus_rd = 1'b0;
  endtask

  logic [31:0] txw [0:7];
  logic [31:0] saved [0:7];
  int          rx_level = 0;

  function automatic logic exp_bit(input int k, input int len);
    int fw, j;
    fw = (len % 32 == 0) ? 32 : len % 32;
    if (k < fw) return txw[0][fw-1-k];
    j = k - fw;
    return txw[1 + j/32][31 - j%32];
  endfunction

  function automatic logic [31:0] exp_rx(input int i, input int len, input logic inv);
    int fw;
    logic [31:0] m;
    fw = (len % 32 == 0) ? 32 : len % 32;
    m  = (i == 0 && fw < 32) ? ((32'd1 << fw) - 32'd1) : 32'hFFFF_FFFF;
    return (txw[i] ^ {32{inv}}) & m;
  endfunction

  task automatic burst(input int len, input int ch, input logic pha, input logic pol,
                       input logic ssp, input int pre, input int post, input int nload,
                       input logic inv, input logic skip_rx, input logic poke,
                       input string tag);
    logic [31:0] cfgv, ctrlv, s, d;
    int nw, bad, first_bad, waited;
    nw = (len + 31) / 32;
    for (int w = 0; w < 8; w++) txw[w] = 32'h0;
    for (int w = 0; w < nload; w++) begin
      txw[w] = $urandom;
      wr(3'd1, txw[w]);
    end
    cfgv = (32'(pha) << ch) | (32'(pol) << (4 + ch)) | (32'(ssp) << (12 + ch)) |
           (32'(pol) << (20 + ch));
    wr(3'd3, cfgv);
    inv_b = inv;
    mon_ch = ch; mon_pol = pol; mon_pha = pha; mon_ssp = ssp;
    mon_act_pat = 4'hF; mon_act_pat[ch] = ssp;
    mon_per = 2 * ((pre + 1) << post);
    cap_n = 0; per_bad = 0; ss_bad = 0; have_lead = 1'b0;
    mon_on = 1'b1;
    ctrlv = (32'(len - 1) << 20) | (32'(ch) << 18) | (32'(pre) << 12) |
            (32'(post) << 8) | 32'hF0 | 32'h5;
    wr(3'd2, ctrlv);
    if (poke) begin
      wr(3'd2, 32'h0000_0005);   // R10: restart attempt while active
      wr(3'd3, 32'h0000_0000);
    end
    waited = 0;
    do begin
      rd(3'd6, s);
      waited++;
    end while (!s[7] && waited < 20000);
    mon_on = 1'b0;
    check(s[7] == 1'b1, {tag, " R8 completion flag"}, s, 32'h80);
    check(cap_n == len, {tag, " R3 bit count"}, cap_n, len);
    bad = 0; first_bad = -1;
    for (int k = 0; k < len && k < cap_n; k++)
      if (cap[k] !== exp_bit(k, len)) begin
        bad++;
        if (first_bad < 0) first_bad = k;
      end
    check(bad == 0, {tag, " R3/R5 serial stream, first bad bit"}, first_bad, -1);
    check(per_bad == 0, {tag, " R7 SCLK period"}, per_bad, 0);
    check(ss_bad == 0, {tag, " R6 select during burst"}, ss_bad, 0);
    begin
      logic [3:0] idle_pat;
      idle_pat = 4'hF; idle_pat[ch] = ~ssp;
      check(ss_o == idle_pat, {tag, " R6 select after burst"}, ss_o, idle_pat);
    end
    check(s[6] == (rx_level + nw > 8), {tag, " R9 overflow flag"}, s[6], rx_level + nw > 8);
    wr(3'd6, 32'hC0);
    rd(3'd6, s);
    check(s[7:6] == 2'b00, {tag, " R8/R9 flags clear on write of one"}, s, 0);
    rd(3'd2, d);
    check(d == (ctrlv & 32'hFFFC_FFF1), {tag, " R8/R10 control after burst"}, d,
          ctrlv & 32'hFFFC_FFF1);
    if (poke) begin
      rd(3'd3, d);
      check(d == cfgv, {tag, " R10 config kept"}, d, cfgv);
    end
    if (skip_rx) begin
      rx_level = (rx_level + nw > 8) ? 8 : rx_level + nw;
    end else begin
      for (int i = 0; i < nw; i++) begin
        rd(3'd0, d);
        check(d == exp_rx(i, len, inv), {tag, " R4 RX word"}, d, exp_rx(i, len, inv));
      end
      rx_level = 0;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int seed;
    seed = $urandom(32'h5A17);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = 3'd0; bus_wdata = '0;
    inv_b = 1'b0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check(ss_o == 4'hF, "R1 selects inactive", ss_o, 4'hF);
    check(sclk_o == 1'b0 && mosi_o == 1'b0, "R1 serial lines low", {sclk_o, mosi_o}, 0);
    rd(3'd6, d); check(d == 0, "R1 status", d, 0);
    rd(3'd2, d); check(d == 0, "R1 control", d, 0);
    rd(3'd3, d); check(d == 0, "R1 config", d, 0);

    // R2 register map
    wr(3'd2, 32'hFFFF_FFFB);
    rd(3'd2, d); check(d == 32'hFFFC_FFF1, "R2 control mask", d, 32'hFFFC_FFF1);
    wr(3'd3, 32'hFFFF_FFFF);
    rd(3'd3, d); check(d == 32'h00F0_F0FF, "R2 config mask", d, 32'h00F0_F0FF);
    for (int a = 4; a < 8; a++) if (a != 6) begin
      wr(3'(a), 32'hFFFF_FFFF);
      rd(3'(a), d); check(d == 0, "R2 unused index reads zero", d, 0);
    end
    rd(3'd0, d); check(d == 0, "R4 empty RX reads zero", d, 0);

    // R13 idle clock level follows picked line
    wr(3'd3, 32'h0040_0000);
    wr(3'd2, 32'h0008_0000);
    @(negedge clk);
    check(sclk_o == 1'b1, "R13 idle level line 2", sclk_o, 1);
    wr(3'd2, 32'h0004_0000);
    @(negedge clk);
    check(sclk_o == 1'b0, "R13 idle level line 1", sclk_o, 0);

    // R12 start without enable
    wr(3'd3, 32'h0);
    wr(3'd2, 32'h0070_0004);
    repeat (60) @(negedge clk);
    rd(3'd2, d); check(d[2] == 1'b0, "R12 start bit not stored", d, 32'h0070_0000);
    rd(3'd6, d); check(d == 0, "R12 no completion", d, 0);
    check(ss_o == 4'hF, "R12 selects stay inactive", ss_o, 4'hF);

    // directed corners
    burst(1,   0, 1'b0, 1'b0, 1'b0, 0, 0, 1, 1'b0, 1'b0, 1'b0, "len1");
    burst(32,  1, 1'b1, 1'b0, 1'b1, 1, 0, 1, 1'b1, 1'b0, 1'b0, "len32");
    burst(33,  2, 1'b1, 1'b1, 1'b0, 0, 1, 2, 1'b0, 1'b0, 1'b0, "len33");
    burst(256, 3, 1'b0, 1'b1, 1'b1, 0, 0, 8, 1'b1, 1'b0, 1'b0, "len256");
    burst(64,  0, 1'b0, 1'b0, 1'b0, 2, 1, 1, 1'b0, 1'b0, 1'b0, "R11 underflow");
    burst(128, 1, 1'b1, 1'b0, 1'b0, 3, 1, 4, 1'b0, 1'b0, 1'b1, "R10 poke");

    // R9 overflow: fill RX with 8 words, then one more word is dropped
    burst(256, 2, 1'b0, 1'b0, 1'b0, 0, 0, 8, 1'b1, 1'b1, 1'b0, "R9 fill");
    for (int i = 0; i < 8; i++) saved[i] = exp_rx(i, 256, 1'b1);
    burst(32, 2, 1'b0, 1'b0, 1'b0, 0, 0, 1, 1'b0, 1'b1, 1'b0, "R9 drop");
    for (int i = 0; i < 8; i++) begin
      rd(3'd0, d); check(d == saved[i], "R9 kept words intact", d, saved[i]);
    end
    rd(3'd0, d); check(d == 0, "R9 dropped word absent", d, 0);
    rx_level = 0;

    // constrained random bursts
    for (int n = 0; n < 12; n++) begin
      int len;
      len = 1 + int'($urandom % 256);
      burst(len, int'($urandom % 4), 1'($urandom), 1'($urandom), 1'($urandom),
            int'($urandom % 3), int'($urandom % 2), (len + 31) / 32, 1'($urandom),
            1'b0, 1'b0, "R5 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule